// File: doc/BRIEF.md
# Redirection-Based Interrupt Message Dispatcher

This block sits between the interrupt input lines of a chip and the fabric that carries interrupt messages to processors. When an event arrives on one of the lines, the block looks up that line's redirection entry in an external table. The entry supplies a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask bit and an 8-bit destination. A masked entry swallows the event. An entry with a usable mode becomes one or more messages on a valid/ready output port.

In physical destination mode the destination field is a single target ID, and one message goes out. In logical destination mode the destination field is a bitmask. The block sends one message for each set bit, lowest bit first, and each message is addressed to that bit's index. For the external-interrupt delivery mode, the vector does not come from the table. The block fetches it from an attached legacy controller through a request/acknowledge handshake. Reserved delivery modes and out-of-range line numbers raise an error pulse and send nothing.

Top module: `irq_msg_dispatch`

## Requirements
- R1: When the entry's mask bit is 1, the event produces no message and no error, even if the entry's mode is reserved, and `evt_ready` is high again in the cycle after acceptance.
- R2: Every message carries the entry's delivery mode, destination-mode bit, polarity (as `msg_level`) and trigger bit. For every mode other than external interrupt, it also carries the entry's vector.
- R3: Delivery mode 3'b111 (external interrupt) raises `ext_req` and holds it until `ext_ack`. No message is presented while the request is pending, and the message vector is the `ext_vec` value sampled with the acknowledge.
- R4: The reserved delivery modes 3'b011 and 3'b110 on an unmasked entry produce no message. Instead `err` is high for the single cycle after acceptance.
- R5: Destination mode 0 (physical) produces exactly one message, and its `msg_target` equals the entry's destination field.
- R6: Destination mode 1 (logical) produces one message for each set bit of the destination, in ascending bit order, with `msg_target` equal to the bit index.
- R7: A logical-mode destination of 8'h00 produces no message and no error.
- R8: A line number of NUM_LINES or more produces no message, and `err` is high in the cycle after acceptance.
- R9: `evt_ready` is low from the acceptance of an event that yields messages until its last message has been accepted.
- R10: While `msg_valid` is high and `msg_ready` is low, the message stays valid and all of its fields hold their values into the next cycle.
- R11: After reset, `evt_ready` is 1 and `msg_valid`, `ext_req` and `err` are 0.
- R12: The delivery-mode encodings are 000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT and 111 external interrupt. Each non-reserved code passes to `msg_dmode` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Interrupt event present |
| evt_ready | output | 1 | Dispatcher can accept an event |
| evt_line | input | LINE_W | Line number of the event |
| tbl_idx | output | LINE_W | Index sent to the redirection table |
| tbl_vector | input | 8 | Entry vector |
| tbl_dmode | input | 3 | Entry delivery mode |
| tbl_logical | input | 1 | Entry destination mode (1 = logical) |
| tbl_polarity | input | 1 | Entry polarity |
| tbl_trigger | input | 1 | Entry trigger mode |
| tbl_mask | input | 1 | Entry mask bit |
| tbl_dest | input | 8 | Entry destination ID or bitmask |
| ext_req | output | 1 | Vector request to the legacy controller |
| ext_ack | input | 1 | Legacy controller acknowledge |
| ext_vec | input | 8 | Vector returned by the legacy controller |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_target | output | 8 | Target processor ID |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level (entry polarity) |
| msg_trigger | output | 1 | Message trigger mode |
| err | output | 1 | One-cycle error pulse |

## Verification
The hardest situation to reach is a logical multi-target sequence whose messages meet receiver back-pressure. For the external-interrupt mode, the same sequence must also wait on a delayed acknowledge. The order and hold behaviour only show when the ready signal stalls partway through the bitmask walk. The bench drives `msg_ready` from a repeating stall pattern that is offset against the message stream, and it answers `ext_req` only after several cycles. It uses wide and sparse masks, including the all-ones mask on the last valid line, so that acceptance happens at several different positions within each sequence.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV_A  = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV_B  = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        dmode_t            dmode;
        logic              logical;
        logic              polarity;
        logic              trigger;
        logic              mask;
        logic [DEST_W-1:0] dest;
    } redir_entry_t;

    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_ERROR = 2'd1,
        ACT_FETCH = 2'd2,
        ACT_SEND  = 2'd3
    } action_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } disp_state_t;

    function automatic logic mode_reserved(input dmode_t m);
        return (m == DM_RSV_A) || (m == DM_RSV_B);
    endfunction

endpackage

// File: rtl/irqd_entry_classify.sv
module irqd_entry_classify
    import irqd_pkg::*;
(
    input  redir_entry_t entry,
    output action_t      action
);
    always_comb begin
        if (entry.mask)
            action = ACT_DROP;
        else if (mode_reserved(entry.dmode))
            action = ACT_ERROR;
        else if (entry.logical && (entry.dest == '0))
            action = ACT_DROP;
        else if (entry.dmode == DM_EXTINT)
            action = ACT_FETCH;
        else
            action = ACT_SEND;
    end
endmodule

// File: rtl/irqd_lowbit.sv
module irqd_lowbit #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  bits_in,
    output logic [IW-1:0] low_idx,
    output logic          any_set
);
    always_comb begin
        low_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_in[i])
                low_idx = IW'(i);
        end
    end

    assign any_set = |bits_in;
endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int LINE_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [LINE_W-1:0] evt_line,
    output logic [LINE_W-1:0] tbl_idx,
    input  logic [7:0]        tbl_vector,
    input  logic [2:0]        tbl_dmode,
    input  logic              tbl_logical,
    input  logic              tbl_polarity,
    input  logic              tbl_trigger,
    input  logic              tbl_mask,
    input  logic [7:0]        tbl_dest,
    output logic              ext_req,
    input  logic              ext_ack,
    input  logic [7:0]        ext_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_target,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_dmode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic              err
);
    localparam int IW = $clog2(DEST_W);

    disp_state_t       state;
    redir_entry_t      cur;
    redir_entry_t      looked;
    logic [DEST_W-1:0] remain;
    logic [DEST_W-1:0] remain_next;
    logic [IW-1:0]     low_idx;
    logic              low_any;
    logic              line_ok;
    logic              accept;
    action_t           action;

    assign tbl_idx = evt_line;

    always_comb begin
        looked.vector   = tbl_vector;
        looked.dmode    = dmode_t'(tbl_dmode);
        looked.logical  = tbl_logical;
        looked.polarity = tbl_polarity;
        looked.trigger  = tbl_trigger;
        looked.mask     = tbl_mask;
        looked.dest     = tbl_dest;
    end

    irqd_entry_classify u_classify (
        .entry  (looked),
        .action (action)
    );

    irqd_lowbit #(.W(DEST_W)) u_lowbit (
        .bits_in (remain),
        .low_idx (low_idx),
        .any_set (low_any)
    );

    assign line_ok     = ({{(32-LINE_W){1'b0}}, evt_line} < 32'(NUM_LINES));
    assign evt_ready   = (state == ST_IDLE);
    assign accept      = evt_valid && evt_ready;
    assign remain_next = remain & (remain - DEST_W'(1));

    assign msg_valid   = (state == ST_SEND);
    assign msg_target  = cur.logical ? {{(DEST_W-IW){1'b0}}, low_idx} : cur.dest;
    assign msg_vector  = cur.vector;
    assign msg_dmode   = cur.dmode;
    assign msg_logical = cur.logical;
    assign msg_level   = cur.polarity;
    assign msg_trigger = cur.trigger;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            remain  <= '0;
            ext_req <= 1'b0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!line_ok) begin
                            err <= 1'b1;
                        end else begin
                            cur    <= looked;
                            remain <= looked.dest;
                            case (action)
                                ACT_ERROR: err <= 1'b1;
                                ACT_FETCH: begin
                                    state   <= ST_FETCH;
                                    ext_req <= 1'b1;
                                end
                                ACT_SEND:  state <= ST_SEND;
                                default:   ;
                            endcase
                        end
                    end
                end
                ST_FETCH: begin
                    if (ext_ack) begin
                        cur.vector <= ext_vec;
                        ext_req    <= 1'b0;
                        state      <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (msg_ready) begin
                        if (!cur.logical) begin
                            state <= ST_IDLE;
                        end else begin
                            remain <= remain_next;
                            if (remain_next == '0)
                                state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_target)
            && $stable(msg_vector) && $stable(msg_dmode) && $stable(msg_level)
            && $stable(msg_trigger) && $stable(msg_logical)));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !evt_ready);

    // R3
    ext_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (!msg_valid && !evt_ready));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && msg_logical)
            |=> (!msg_valid || (msg_target > $past(msg_target))));

    // R4
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (evt_ready && !msg_valid));

    // R12
    no_rsv_out_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !mode_reserved(dmode_t'(msg_dmode)));

    // R6
    logical_target_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_logical) |-> low_any);
endmodule

// File: tb/irq_msg_dispatch_bench.sv
module irq_msg_dispatch_bench;
    localparam int NL = 24;
    localparam int LW = 5;

    typedef struct packed {
        logic [7:0] target;
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic       trigger;
    } exp_msg_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          evt_valid = 1'b0;
    logic          evt_ready;
    logic [LW-1:0] evt_line = '0;
    logic [LW-1:0] tbl_idx;
    logic [7:0]    tbl_vector, tbl_dest;
    logic [2:0]    tbl_dmode;
    logic          tbl_logical, tbl_polarity, tbl_trigger, tbl_mask;
    logic          ext_req;
    logic          ext_ack = 1'b0;
    logic [7:0]    ext_vec = 8'h00;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_target, msg_vector;
    logic [2:0]    msg_dmode;
    logic          msg_logical, msg_level, msg_trigger;
    logic          err;

    logic [7:0] m_vec   [32];
    logic [2:0] m_mode  [32];
    logic       m_log   [32];
    logic       m_pol   [32];
    logic       m_trg   [32];
    logic       m_msk   [32];
    logic [7:0] m_dst   [32];

    assign tbl_vector   = m_vec[tbl_idx];
    assign tbl_dmode    = m_mode[tbl_idx];
    assign tbl_logical  = m_log[tbl_idx];
    assign tbl_polarity = m_pol[tbl_idx];
    assign tbl_trigger  = m_trg[tbl_idx];
    assign tbl_mask     = m_msk[tbl_idx];
    assign tbl_dest     = m_dst[tbl_idx];

    irq_msg_dispatch #(.NUM_LINES(NL), .LINE_W(LW)) u_irq_msg_dispatch (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_line(evt_line), .tbl_idx(tbl_idx), .tbl_vector(tbl_vector),
        .tbl_dmode(tbl_dmode), .tbl_logical(tbl_logical),
        .tbl_polarity(tbl_polarity), .tbl_trigger(tbl_trigger),
        .tbl_mask(tbl_mask), .tbl_dest(tbl_dest), .ext_req(ext_req),
        .ext_ack(ext_ack), .ext_vec(ext_vec), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_target(msg_target), .msg_vector(msg_vector),
        .msg_dmode(msg_dmode), .msg_logical(msg_logical), .msg_level(msg_level),
        .msg_trigger(msg_trigger), .err(err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    exp_msg_t expq[$];

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic set_entry(input int i, input logic [7:0] v, input logic [2:0] md,
                             input logic lg, input logic pl, input logic tg,
                             input logic mk, input logic [7:0] d);
        m_vec[i] = v; m_mode[i] = md; m_log[i] = lg; m_pol[i] = pl;
        m_trg[i] = tg; m_msk[i] = mk; m_dst[i] = d;
    endtask

    // Driver: predicts the messages from the requirements and pushes them.
    task automatic send_evt(input int line);
        bit       exp_err;
        int       n_exp;
        exp_msg_t e;
        exp_err = 1'b0;
        n_exp = 0;
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1;
        evt_line  = LW'(line);
        if (line >= NL) begin
            exp_err = 1'b1;                              // R8
        end else if (!m_msk[line]) begin                 // R1
            if (m_mode[line] == 3'b011 || m_mode[line] == 3'b110) begin
                exp_err = 1'b1;                          // R4
            end else begin
                e.vector  = (m_mode[line] == 3'b111) ? ext_vec : m_vec[line]; // R3
                e.dmode   = m_mode[line];
                e.logical = m_log[line];
                e.level   = m_pol[line];
                e.trigger = m_trg[line];
                if (!m_log[line]) begin                  // R5
                    e.target = m_dst[line];
                    expq.push_back(e);
                    n_exp++;
                end else begin                           // R6, R7
                    for (int b = 0; b < 8; b++) begin
                        if (m_dst[line][b]) begin
                            e.target = 8'(b);
                            expq.push_back(e);
                            n_exp++;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        evt_valid = 1'b0;
        check(err == exp_err, $sformatf("R4 R8 err after line %0d", line), int'(err), int'(exp_err));
        if (n_exp > 0)
            check(!evt_ready, $sformatf("R9 busy after line %0d", line), int'(evt_ready), 0);
        else
            check(evt_ready, $sformatf("R1 R7 ready after line %0d", line), int'(evt_ready), 1);
    endtask

    // Legacy controller model: acknowledge after a delay.
    int ack_wait = 0;
    always @(negedge clk) begin
        if (ext_req && !ext_ack) begin
            ack_wait++;
            if (ack_wait >= 4) begin
                ext_ack = 1'b1;
                ack_wait = 0;
            end
        end else begin
            ext_ack = 1'b0;
        end
    end

    // Monitor: receiver with a stall pattern, scoreboard compare and hold check.
    bit       was_stalled = 1'b0;
    exp_msg_t held;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (was_stalled) begin
                check(msg_valid && msg_target == held.target && msg_vector == held.vector,
                      "R10 held message", int'(msg_target), int'(held.target));
            end
            msg_ready = ((cyc % 5) != 1) && ((cyc % 7) != 3);
            if (msg_valid && msg_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R1 R4 R7 unexpected message", int'(msg_target), 0);
                end else begin
                    exp_msg_t e;
                    e = expq.pop_front();
                    check(msg_target == e.target, "R5 R6 target", int'(msg_target), int'(e.target));
                    check(msg_vector == e.vector, "R2 R3 vector", int'(msg_vector), int'(e.vector));
                    check({msg_dmode, msg_logical, msg_level, msg_trigger} ==
                          {e.dmode, e.logical, e.level, e.trigger},
                          "R2 R12 fields", int'({msg_dmode, msg_logical, msg_level, msg_trigger}),
                          int'({e.dmode, e.logical, e.level, e.trigger}));
                end
            end
            was_stalled = msg_valid && !msg_ready;
            held.target = msg_target;
            held.vector = msg_vector;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) set_entry(i, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        set_entry(0,  8'h31, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05);
        set_entry(1,  8'h99, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
        set_entry(2,  8'h42, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5);
        set_entry(3,  8'h50, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02);
        set_entry(4,  8'h51, 3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02);
        set_entry(5,  8'h52, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        set_entry(6,  8'h53, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 8'h03);
        set_entry(7,  8'h54, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 8'h82);
        set_entry(8,  8'h60, 3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
        set_entry(9,  8'h61, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80);
        set_entry(10, 8'h62, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01);
        set_entry(23, 8'h77, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);

        repeat (3) @(negedge clk);
        // R11
        check(evt_ready && !msg_valid && !ext_req && !err, "R11 reset state",
              int'({evt_ready, msg_valid, ext_req, err}), 8);
        rst = 1'b0;
        @(negedge clk);

        send_evt(0);
        send_evt(1);
        send_evt(2);
        send_evt(3);
        send_evt(4);
        send_evt(5);
        ext_vec = 8'hC3;
        send_evt(6);
        while (!evt_ready) @(negedge clk);
        ext_vec = 8'hD7;
        send_evt(7);
        while (!evt_ready) @(negedge clk);
        send_evt(8);
        send_evt(9);
        send_evt(10);
        send_evt(24);
        send_evt(31);
        send_evt(23);
        send_evt(2);
        send_evt(0);

        while (!evt_ready || msg_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5 R6 all expected messages seen", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule